// File: doc/BRIEF.md
# PLL Retune Clock Parking Sequencer

This block steers the two clock multiplexers in front of a processor clock while the upstream PLL is reprogrammed. When a pre-change request arrives, it moves the processor clock onto the crystal. It waits a settle interval and then switches the divider input over to the PLL. The processor keeps running on the crystal through the retune. When a post-change request arrives, the block waits for the PLL to report lock. It then puts the processor back on the divided PLL path and waits a second settle interval before it reports completion.

The settle and lock intervals are counted in ticks of a timer strobe. An optional prescaler can sit in front of that strobe. At 24 MHz with one tick per cycle, a settle interval of 2400 ticks gives 100 us. The block leaves reset parked, which means the output runs from the crystal and the divider input has not yet been switched to the PLL. In that state it waits for a post-change request.

Top module: `clk_park_seq`

## Requirements
- R1: After reset, out_sel=0 (processor on crystal), in_sel=0, busy=0, done=0, lock_err=0 and orphan_post=0. The block is in the parked state.
- R2: A pre_req sampled while the block is not busy is accepted. Starting the next cycle, out_sel=0 and busy=1, and in_sel keeps its previous value.
- R3: in_sel becomes 1 only after SETTLE_TICKS timer ticks have been counted since the park began. out_sel stays 0 for the whole interval. With a tick every cycle, in_sel and done appear SETTLE_TICKS cycles after busy rises.
- R4: A post_req accepted in the parked state leaves out_sel=0 for as long as pll_lock is low.
- R5: Once pll_lock is high during the lock wait, out_sel=1 from the next cycle on. After a further SETTLE_TICKS ticks, done pulses and busy falls.
- R6: If pll_lock stays low for LOCK_TICKS ticks, the block returns to the parked state with out_sel=0 and pulses done. It sets lock_err=1, which stays set until the next accepted request clears it.
- R7: A post_req sampled while the block is running on the divided path (not parked and not busy) is ignored. Outputs keep their values, and orphan_post pulses for exactly one cycle.
- R8: Any pre_req or post_req that arrives while busy=1 is ignored. The current phase ends at the same cycle it would have ended without the extra request.
- R9: done is high for exactly one cycle at the end of each phase. busy is high from the cycle after acceptance until done, and busy is low in the done cycle.
- R10: The settle and lock counters advance only on ticks. With tick held low, a phase never ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_req | input | 1 | Request to park before a PLL retune |
| post_req | input | 1 | Request to restore after a PLL retune |
| pll_lock | input | 1 | PLL lock indication |
| tick | input | 1 | Timer strobe for settle and lock counting |
| out_sel | output | 1 | Output mux select: 1 = divided PLL path, 0 = crystal |
| in_sel | output | 1 | Divider input mux select: 1 = PLL |
| busy | output | 1 | A phase is in progress |
| done | output | 1 | One-cycle pulse at the end of a phase |
| lock_err | output | 1 | Sticky flag: the lock wait timed out |
| orphan_post | output | 1 | One-cycle pulse: a post-change request arrived with no park before it |

## Verification
The bench controls the order of the two mux moves and the settle count on each edge. A design that switched the divider input before parking, or that ended a settle one tick early or late, would show in_sel or done in the wrong cycle. It holds lock low through a late-lock restore and through a full timeout. A design that restored without lock, or that failed to park again and flag the timeout, would therefore show out_sel=1 or lock_err=0. It sends extra requests during a phase and a post request with no park before it. A design that restarted its timer or acted on an orphan request would shift done or change out_sel. Finally, it holds tick low to catch a timer that counts cycles instead of ticks.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;
   typedef enum logic [2:0] {
      PS_RUN         = 3'd0,
      PS_PARK_SETTLE = 3'd1,
      PS_PARKED      = 3'd2,
      PS_WAIT_LOCK   = 3'd3,
      PS_RESTORE     = 3'd4
   } park_state_e;

   function automatic logic is_busy_state(park_state_e s);
      return (s == PS_PARK_SETTLE) || (s == PS_WAIT_LOCK) || (s == PS_RESTORE);
   endfunction
endpackage

// File: rtl/clk_park_prescale.sv
module clk_park_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_out
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (tick_in) begin
         if (pc_q == LAST) pc_q <= '0;
         else              pc_q <= pc_q + 1'b1;
      end
   end

   assign tick_out = tick_in && (pc_q == LAST);
endmodule

// File: rtl/clk_park_timer.sv
module clk_park_timer #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic          tick,
   input  logic [CW-1:0] last,
   output logic          expire
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run && tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = run && tick && (cnt_q == last);

   // R10: no tick, no advance
   p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !tick) |=> $stable(cnt_q));

   // R3: the count never runs past the interval end
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr) |-> (cnt_q <= last));
endmodule

// File: rtl/clk_park_fsm.sv
module clk_park_fsm
   import clk_park_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pre_req,
   input  logic post_req,
   input  logic pll_lock,
   input  logic expire,
   output logic tmr_clr,
   output logic tmr_run,
   output logic tmr_lock_sel,
   output logic out_sel,
   output logic in_sel,
   output logic busy,
   output logic done,
   output logic lock_err,
   output logic orphan_post
);
   park_state_e st_q, st_d;
   logic out_q, out_d, in_q, in_d;
   logic done_q, done_d, err_q, err_d, orph_q, orph_d;

   always_comb begin
      st_d   = st_q;
      out_d  = out_q;
      in_d   = in_q;
      done_d = 1'b0;
      orph_d = 1'b0;
      err_d  = err_q;
      unique case (st_q)
         PS_RUN: begin
            if (pre_req) begin
               st_d  = PS_PARK_SETTLE;
               out_d = 1'b0;
               err_d = 1'b0;
            end else if (post_req) begin
               orph_d = 1'b1;
            end
         end
         PS_PARKED: begin
            if (pre_req) begin
               st_d  = PS_PARK_SETTLE;
               err_d = 1'b0;
            end else if (post_req) begin
               st_d  = PS_WAIT_LOCK;
               err_d = 1'b0;
            end
         end
         PS_PARK_SETTLE: begin
            if (expire) begin
               st_d   = PS_PARKED;
               in_d   = 1'b1;
               done_d = 1'b1;
            end
         end
         PS_WAIT_LOCK: begin
            if (pll_lock) begin
               st_d  = PS_RESTORE;
               out_d = 1'b1;
            end else if (expire) begin
               st_d   = PS_PARKED;
               err_d  = 1'b1;
               done_d = 1'b1;
            end
         end
         PS_RESTORE: begin
            if (expire) begin
               st_d   = PS_RUN;
               done_d = 1'b1;
            end
         end
         default: st_d = PS_PARKED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_PARKED;
         out_q  <= 1'b0;
         in_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         orph_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         out_q  <= out_d;
         in_q   <= in_d;
         done_q <= done_d;
         err_q  <= err_d;
         orph_q <= orph_d;
      end
   end

   assign tmr_clr      = (st_d != st_q);
   assign tmr_run      = is_busy_state(st_q);
   assign tmr_lock_sel = (st_q == PS_WAIT_LOCK);
   assign out_sel      = out_q;
   assign in_sel       = in_q;
   assign busy         = is_busy_state(st_q);
   assign done         = done_q;
   assign lock_err     = err_q;
   assign orphan_post  = orph_q;

   // R3: divider input only moves while the output is on the crystal
   p_in_after_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_q) |-> !out_q);

   // R4: output returns to the PLL path only after lock was seen
   p_restore_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> $past(pll_lock));

   // R9: done is a single-cycle pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R9: busy only drops together with done
   p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q);

   // R7: orphan flag only while running on the divided path
   p_orphan_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      orph_q |-> (out_q && !busy));

   // R6: timeout leaves the output parked and closes the phase
   p_timeout_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> (!out_q && done_q));
endmodule

// File: rtl/clk_park_seq.sv
module clk_park_seq #(
   parameter int SETTLE_TICKS = 2400,
   parameter int LOCK_TICKS   = 24000,
   parameter int TICK_DIV     = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pre_req,
   input  logic post_req,
   input  logic pll_lock,
   input  logic tick,
   output logic out_sel,
   output logic in_sel,
   output logic busy,
   output logic done,
   output logic lock_err,
   output logic orphan_post
);
   localparam int MAXT = (SETTLE_TICKS > LOCK_TICKS) ? SETTLE_TICKS : LOCK_TICKS;
   localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
   localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_TICKS - 1);
   localparam logic [CW-1:0] LOCK_LAST   = CW'(LOCK_TICKS - 1);

   generate
      if (SETTLE_TICKS < 1) begin : g_bad_settle
         $error("SETTLE_TICKS must be at least 1");
      end
      if (LOCK_TICKS < 1) begin : g_bad_lock
         $error("LOCK_TICKS must be at least 1");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic tick_eff;
   logic t_clr, t_run, t_lock_sel, t_exp;
   logic [CW-1:0] t_last;

   generate
      if (TICK_DIV > 1) begin : g_presc
         clk_park_prescale #(.DIV(TICK_DIV)) u_presc (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_in  (tick),
            .tick_out (tick_eff)
         );
      end else begin : g_direct
         assign tick_eff = tick;
      end
   endgenerate

   assign t_last = t_lock_sel ? LOCK_LAST : SETTLE_LAST;

   clk_park_timer #(.CW(CW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (t_clr),
      .run    (t_run),
      .tick   (tick_eff),
      .last   (t_last),
      .expire (t_exp)
   );

   clk_park_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .pre_req      (pre_req),
      .post_req     (post_req),
      .pll_lock     (pll_lock),
      .expire       (t_exp),
      .tmr_clr      (t_clr),
      .tmr_run      (t_run),
      .tmr_lock_sel (t_lock_sel),
      .out_sel      (out_sel),
      .in_sel       (in_sel),
      .busy         (busy),
      .done         (done),
      .lock_err     (lock_err),
      .orphan_post  (orphan_post)
   );
endmodule

// File: tb/clk_park_seq_test.sv
`timescale 1ns/1ps
module clk_park_seq_test;
   localparam int ST = 4;
   localparam int LT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pre_req = 1'b0, post_req = 1'b0, pll_lock = 1'b0, tick = 1'b1;
   logic out_sel, in_sel, busy, done, lock_err, orphan_post;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   clk_park_seq #(.SETTLE_TICKS(ST), .LOCK_TICKS(LT), .TICK_DIV(1)) uut (
      .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .post_req(post_req),
      .pll_lock(pll_lock), .tick(tick), .out_sel(out_sel), .in_sel(in_sel),
      .busy(busy), .done(done), .lock_err(lock_err), .orphan_post(orphan_post)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_bit(input string req, input logic act, input logic exp);
      chk(act === exp, req, int'(act), int'(exp));
   endtask

   task automatic t_reset;
      chk_bit("R1 out_sel", out_sel, 1'b0);
      chk_bit("R1 in_sel", in_sel, 1'b0);
      chk_bit("R1 busy", busy, 1'b0);
      chk_bit("R1 done", done, 1'b0);
      chk_bit("R1 lock_err", lock_err, 1'b0);
      chk_bit("R1 orphan_post", orphan_post, 1'b0);
   endtask

   // post-change restore; lock goes high lock_delay cycles after acceptance
   task automatic t_restore(input int lock_delay);
      pll_lock = (lock_delay == 0);
      @(negedge clk); post_req = 1'b1;
      @(negedge clk); post_req = 1'b0;
      chk_bit("R4 busy on accept", busy, 1'b1);
      chk_bit("R4 out_sel parked", out_sel, 1'b0);
      chk_bit("R6 lock_err cleared on accept", lock_err, 1'b0);
      for (int d = 0; d < lock_delay; d++) begin
         @(negedge clk);
         chk_bit("R4 no restore without lock", out_sel, 1'b0);
         if (d == lock_delay - 1) pll_lock = 1'b1;
      end
      @(negedge clk);
      chk_bit("R5 out_sel restored", out_sel, 1'b1);
      chk_bit("R5 busy in settle", busy, 1'b1);
      for (int i = 1; i < ST; i++) begin
         @(negedge clk);
         chk_bit("R5 no early done", done, 1'b0);
         chk_bit("R9 busy held", busy, 1'b1);
      end
      @(negedge clk);
      chk_bit("R5 done at settle end", done, 1'b1);
      chk_bit("R9 busy low with done", busy, 1'b0);
      @(negedge clk);
      chk_bit("R9 done one cycle", done, 1'b0);
      chk_bit("R5 out_sel kept", out_sel, 1'b1);
   endtask

   task automatic t_orphan;
      @(negedge clk); post_req = 1'b1;
      @(negedge clk); post_req = 1'b0;
      chk_bit("R7 orphan flagged", orphan_post, 1'b1);
      chk_bit("R7 out_sel unchanged", out_sel, 1'b1);
      chk_bit("R7 not busy", busy, 1'b0);
      @(negedge clk);
      chk_bit("R7 orphan one cycle", orphan_post, 1'b0);
      chk_bit("R7 no done", done, 1'b0);
   endtask

   // pre-change park; intrude adds requests mid-phase, gate holds tick low first
   task automatic t_park(input logic intrude, input logic gate);
      logic prev_in;
      prev_in = in_sel;
      if (gate) tick = 1'b0;
      @(negedge clk); pre_req = 1'b1;
      @(negedge clk); pre_req = 1'b0;
      chk_bit("R2 busy on accept", busy, 1'b1);
      chk_bit("R2 out_sel to crystal", out_sel, 1'b0);
      chk_bit("R2 in_sel not yet moved", in_sel, prev_in);
      if (gate) begin
         for (int g = 0; g < 8; g++) begin
            @(negedge clk);
            chk_bit("R10 no progress without tick", busy, 1'b1);
         end
         chk_bit("R10 in_sel held", in_sel, prev_in);
         tick = 1'b1;
      end
      for (int i = 1; i < ST; i++) begin
         @(negedge clk);
         chk_bit("R3 in_sel waits for settle", in_sel, prev_in);
         chk_bit("R3 out_sel stays crystal", out_sel, 1'b0);
         chk_bit("R9 busy held", busy, 1'b1);
         pre_req  = intrude && (i == 1);
         post_req = intrude && (i == 2);
      end
      pre_req = 1'b0; post_req = 1'b0;
      @(negedge clk);
      chk_bit("R3 in_sel set after settle", in_sel, 1'b1);
      chk_bit(intrude ? "R8 done timing unchanged" : "R9 done at end", done, 1'b1);
      chk_bit("R9 busy low with done", busy, 1'b0);
      @(negedge clk);
      chk_bit("R9 done one cycle", done, 1'b0);
      chk_bit("R8 no restart", busy, 1'b0);
   endtask

   task automatic t_timeout;
      pll_lock = 1'b0;
      @(negedge clk); post_req = 1'b1;
      @(negedge clk); post_req = 1'b0;
      chk_bit("R6 busy on accept", busy, 1'b1);
      for (int i = 1; i < LT; i++) begin
         @(negedge clk);
         chk_bit("R6 waiting", busy, 1'b1);
         chk_bit("R6 out_sel parked", out_sel, 1'b0);
      end
      @(negedge clk);
      chk_bit("R6 done on timeout", done, 1'b1);
      chk_bit("R6 lock_err set", lock_err, 1'b1);
      chk_bit("R6 out_sel stays crystal", out_sel, 1'b0);
      chk_bit("R6 busy low", busy, 1'b0);
      repeat (3) @(negedge clk);
      chk_bit("R6 lock_err sticky", lock_err, 1'b1);
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_restore(3);
      t_orphan();
      t_park(1'b0, 1'b0);
      t_restore(0);
      t_park(1'b1, 1'b0);
      t_timeout();
      t_restore(2);
      t_park(1'b0, 1'b1);
      t_park(1'b0, 1'b0);
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule